// File: doc/BRIEF.md
# Two-Channel LED Dimmer Serial Register Interface

This block is the serial front end of a two-channel LED dimmer. It behaves as an I2C slave. It recognises its own 7-bit address, in which the lowest bit is taken from a strap input. It stores a control byte that holds a register pointer and an auto-increment flag. It then writes or reads a small bank of registers. The bank holds two period prescalers, two duty values and an LED selector, and these values feed the dimming logic through dedicated outputs. A read-only slot returns the live levels of the two LED pins.

SCL and SDA are sampled through a two-flop synchronizer on the system clock. START and STOP are detected from the synchronized lines. SDA is driven open-drain: `sda_oe` high pulls the line low. The slave never stretches the clock. The protocol engine is a single state machine with ten states:

- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the acknowledge for the address.
- `ST_CTRL`: shifts in the control byte.
- `ST_CTRL_ACK`: drives the acknowledge for the control byte.
- `ST_WDATA`: shifts in a write byte.
- `ST_WDATA_ACK`: drives the acknowledge for a write byte.
- `ST_RDATA`: shifts out a read byte.
- `ST_RDATA_ACK`: samples the master's acknowledge.
- `ST_HOLD`: keeps SDA released until the next START or STOP.

Transitions:

- A START moves any state to `ST_ADDR`.
- A STOP moves any state to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` on an address match, and to `ST_HOLD` otherwise.
- `ST_ADDR_ACK` moves to `ST_RDATA` for a read, and to `ST_CTRL` for a write.
- `ST_CTRL` moves to `ST_CTRL_ACK`, which moves to `ST_WDATA`.
- `ST_WDATA` moves to `ST_WDATA_ACK`, which returns to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` moves to `ST_RDATA` when the master acknowledges, and to `ST_HOLD` when it does not.

All moves between byte and acknowledge states take place on a falling SCL edge.

Top module: `ledim_i2c_regs`

## Requirements
- R1: The slave answers the 7-bit address 110000 followed by `addr_strap`, with R/W as the eighth bit (1 = read). On a match it pulls SDA low for the acknowledge bit. Any other address gets no acknowledge, and the rest of that transfer has no effect.
- R2: In a write transfer, the first byte after the address goes to the control register. Bits [2:0] of that byte are the register pointer and bit 4 is the auto-increment flag. The byte is acknowledged.
- R3: Data bytes are acknowledged. A data byte is stored at the pointer when the pointer is 1 to 5:
  - index 1 appears on `prescale0`
  - index 2 appears on `duty0`
  - index 3 appears on `prescale1`
  - index 4 appears on `duty1`
  - index 5 appears on `led_sel`

  These outputs change only on such a write. Indices 6 and 7 read as 00h.
- R4: When auto-increment is set, the pointer advances after every data byte, whether written or read. From 5 (or 6 or 7) it wraps to 0.
- R5: When auto-increment is clear, the pointer stays where it is, so repeated bytes access the same register.
- R6: A write to index 0 is acknowledged and changes nothing. A read of index 0 returns `led_level` in bits [1:0], with zeros above.
- R7: While `rst_n` is low, the block is held at its defaults: prescalers 00h, both duty registers 80h, LED selector 00h (both LEDs off), control register 00h, and SDA released.
- R8: A STOP or a repeated START ends the current transfer, and a byte that is not complete is discarded. A master NACK after a read byte leaves SDA released until the next START.
- R9: Bytes are shifted MSB first, and SDA is sampled on the rising edge of SCL. The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Level of the strap that sets address bit 0 |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| led_level | input | 2 | Live levels of the two LED pins |
| prescale0 | output | 8 | Period prescaler for channel 0 |
| duty0 | output | 8 | Duty value for channel 0 |
| prescale1 | output | 8 | Period prescaler for channel 1 |
| duty1 | output | 8 | Duty value for channel 1 |
| led_sel | output | 8 | LED selector value |

## Verification
Write bursts are driven with auto-increment both set and clear. Comparing the per-clock register outputs shows whether the pointer walks through the bank or stays on one entry.

A read burst that starts at index 3 and runs past index 5 separates a wrapping pointer from one that saturates. The same burst shows whether the live pin levels are returned from index 0.

Other patterns each target one failure:

- A foreign address, and the same address under both strap levels, expose a bad address compare.
- A write aimed at the read-only slot exposes a slot that accepts stores.
- A STOP in the middle of a byte exposes a byte committed too early.
- Clocking extra bits after a master NACK exposes a slave that keeps driving SDA.

// File: rtl/ledim_pkg.sv
package ledim_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_HOLD
    } link_state_t;

    // Pointer step with wrap back to the read-only slot
    function automatic logic [2:0] ptr_step(input logic [2:0] cur, input logic [2:0] last);
        return (cur >= last) ? 3'd0 : cur + 3'd1;
    endfunction

endpackage

// File: rtl/ledim_bus_sync.sv
module ledim_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/ledim_regbank.sv
module ledim_regbank #(
    parameter int          DW       = 8,
    parameter int          NREG     = 6,
    parameter int          PIN_W    = 2,
    parameter logic [7:0]  DUTY_RST = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [2:0]               rd_idx,
    input  logic [PIN_W-1:0]         pin_lvl,
    output logic [DW-1:0]            rd_data,
    output logic [(NREG-1)*DW-1:0]   regs_flat
);

    logic [DW-1:0] store [1:NREG-1];

    // Duty entries (indices 2 and 4) start at half scale
    function automatic logic [DW-1:0] rst_of(input int idx);
        return (idx == 2 || idx == 4) ? DW'(DUTY_RST) : '0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i < NREG; i++) store[i] <= rst_of(i);
        end else if (wr_en && wr_idx != 3'd0 && int'(wr_idx) < NREG) begin
            store[int'(wr_idx)] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == 3'd0) begin
            rd_data[PIN_W-1:0] = pin_lvl;
        end else begin
            for (int i = 1; i < NREG; i++)
                if (int'(rd_idx) == i) rd_data = store[i];
        end
    end

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_flat
            assign regs_flat[(g-1)*DW +: DW] = store[g];
        end
    endgenerate

endmodule

// File: rtl/ledim_link_fsm.sv
module ledim_link_fsm
    import ledim_pkg::*;
#(
    parameter int         DW       = 8,
    parameter logic [5:0] ADDR_HI  = 6'b110000,
    parameter logic [2:0] LAST_IDX = 3'd5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_strap,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [2:0]    wr_idx,
    output logic [DW-1:0] wr_data,
    output logic [2:0]    ptr,
    output logic          ai
);

    localparam int            CNT_W     = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(DW);
    localparam int            AI_BIT    = 4;

    link_state_t      state;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]    rx_sh;
    logic [DW-1:0]    tx_sh;
    logic [DW-1:0]    ctrl;
    logic             rw;
    logic             mack;
    logic             full;

    assign full = (bitcnt == FULL);
    assign ptr  = ctrl[2:0];
    assign ai   = ctrl[AI_BIT];

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '1;
            ctrl   <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: begin
                end
                ST_ADDR, ST_CTRL, ST_WDATA: begin
                    if (scl_rise && !full) begin
                        rx_sh  <= {rx_sh[DW-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && full) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rx_sh[DW-1:1] == {ADDR_HI, addr_strap}) begin
                                rw    <= rx_sh[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end else if (state == ST_CTRL) begin
                            ctrl  <= rx_sh;
                            state <= ST_CTRL_ACK;
                        end else begin
                            if (ai) ctrl[2:0] <= ptr_step(ctrl[2:0], LAST_IDX);
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            tx_sh <= rd_data;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_CTRL;
                        end
                    end
                end
                ST_CTRL_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) state <= ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_rise && !full) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (full) begin
                            bitcnt <= '0;
                            tx_sh  <= '1;
                            if (ai) ctrl[2:0] <= ptr_step(ctrl[2:0], LAST_IDX);
                            state  <= ST_RDATA_ACK;
                        end else begin
                            tx_sh <= {tx_sh[DW-2:0], 1'b1};
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx_sh <= rd_data;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CTRL_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_sh[DW-1];
            ST_WDATA: wr_en  = scl_fall & full & ~start_det & ~stop_det;
            default: begin
            end
        endcase
    end

    assign wr_idx  = ctrl[2:0];
    assign wr_data = rx_sh;

endmodule

// File: rtl/ledim_i2c_regs.sv
module ledim_i2c_regs #(
    parameter int         DW          = 8,
    parameter int         NREG        = 6,
    parameter int         PIN_W       = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b110000,
    parameter logic [7:0] DUTY_RST    = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_strap,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [PIN_W-1:0] led_level,
    output logic [DW-1:0]    prescale0,
    output logic [DW-1:0]    duty0,
    output logic [DW-1:0]    prescale1,
    output logic [DW-1:0]    duty1,
    output logic [DW-1:0]    led_sel
);

    localparam logic [2:0] LAST_IDX = 3'(NREG - 1);

    logic                   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                   wr_en, ai;
    logic [2:0]             wr_idx, ptr;
    logic [DW-1:0]          wr_data, rd_data;
    logic [(NREG-1)*DW-1:0] regs_flat;

    ledim_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ledim_link_fsm #(.DW(DW), .ADDR_HI(ADDR_HI), .LAST_IDX(LAST_IDX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr), .ai(ai)
    );

    ledim_regbank #(.DW(DW), .NREG(NREG), .PIN_W(PIN_W), .DUTY_RST(DUTY_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(ptr), .pin_lvl(led_level), .rd_data(rd_data), .regs_flat(regs_flat)
    );

    assign prescale0 = regs_flat[0*DW +: DW];
    assign duty0     = regs_flat[1*DW +: DW];
    assign prescale1 = regs_flat[2*DW +: DW];
    assign duty1     = regs_flat[3*DW +: DW];
    assign led_sel   = regs_flat[4*DW +: DW];

endmodule

// File: rtl/ledim_chk.sv
module ledim_chk #(
    parameter int RW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [2:0]    wr_idx,
    input logic          ai,
    input logic [RW-1:0] regs_flat
);

    // R9: slave output moves only while the synchronized clock is low
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8: a STOP leaves SDA released
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R6: a store aimed at the read-only slot leaves the bank untouched
    p_ro_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 3'd0) |=> $stable(regs_flat));

    // R3: bank contents move only on a write strobe
    p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R4: auto-increment wraps from the last slot to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ai && wr_idx == 3'd5) |=> wr_idx == 3'd0);

endmodule

bind ledim_i2c_regs ledim_chk #(.RW((NREG-1)*DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .ai(ai), .regs_flat(regs_flat)
);

// File: tb/test_ledim_i2c_regs.sv
`timescale 1ns/1ps
module test_ledim_i2c_regs;

    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       strap = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] lvl = 2'b10;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] psc0, dut0, psc1, dut1, sel;

    int  total = 0;
    int  bad = 0;
    bit  cmp_en = 1'b0;

    // Reference model state
    logic [7:0] ex [0:5];
    logic [2:0] eptr;
    bit         eai;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    ledim_i2c_regs i_ledim_i2c_regs (
        .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .led_level(lvl), .prescale0(psc0), .duty0(dut0),
        .prescale1(psc1), .duty1(dut1), .led_sel(sel)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) ex[i] = 8'h00;
        ex[2] = 8'h80; ex[4] = 8'h80; eptr = 3'd0; eai = 1'b0;
    endtask

    function automatic logic [2:0] m_step(input logic [2:0] p);
        return (p >= 3'd5) ? 3'd0 : p + 3'd1;
    endfunction

    // Compare the register outputs against the model on every clock while idle
    always @(negedge clk) begin
        if (cmp_en) begin
            chk({psc0, dut0, psc1, dut1, sel} == {ex[1], ex[2], ex[3], ex[4], ex[5]}, "R3",
                "register outputs", int'({psc0, dut0, psc1, dut1}), int'({ex[1], ex[2], ex[3], ex[4]}));
            chk(sel == ex[5], "R3", "led_sel", int'(sel), int'(ex[5]));
            chk(sda_oe == 1'b0, "R8", "idle sda_oe", int'(sda_oe), 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic b_start();
        cmp_en = 1'b0;
        m_sda = 1'b1; m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic b_rstart();
        tick(4); m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic b_stop();
        tick(4); m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
        cmp_en = 1'b1;
    endtask

    task automatic wbit(input bit b);
        tick(4); m_sda = b; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic rbit(output bit b);
        tick(4); m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        b = sda_bus; tick(H/2);
        m_scl = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic rbyte(output logic [7:0] d, input bit give_ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            d[i] = x;
        end
        wbit(~give_ack);
    endtask

    task automatic m_write(input logic [7:0] d);
        if (eptr >= 3'd1 && eptr <= 3'd5) ex[eptr] = d;
        if (eai) eptr = m_step(eptr);
    endtask

    task automatic m_read(output logic [7:0] d);
        d = (eptr == 3'd0) ? {6'b0, lvl} : (eptr <= 3'd5 ? ex[eptr] : 8'h00);
        if (eai) eptr = m_step(eptr);
    endtask

    task automatic wr_burst(input logic [7:0] ctl, input logic [7:0] d [], input string req);
        bit ack;
        b_start();
        wbyte({6'b110000, strap, 1'b0}, ack); chk(ack, "R1", "address ack", ack, 1);
        wbyte(ctl, ack); chk(ack, "R2", "control ack", ack, 1);
        eptr = ctl[2:0]; eai = ctl[4];
        foreach (d[i]) begin
            wbyte(d[i], ack); chk(ack, req, "data ack", ack, 1);
            m_write(d[i]);
        end
        b_stop();
    endtask

    initial begin
        bit         ack;
        bit         x;
        logic [7:0] got, exp;
        logic [7:0] d [];
        rst_n = 1'b0;
        model_reset();
        tick(10);
        // R7: defaults while reset is held
        chk({psc0, dut0, psc1, dut1, sel} == 40'h00_80_00_80_00, "R7", "reset values",
            int'({dut0, dut1}), 16'h8080);
        chk(sda_oe == 1'b0, "R7", "reset sda_oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(5);
        cmp_en = 1'b1;
        tick(20);

        // R1: a foreign address is ignored
        b_start();
        wbyte(8'hC4, ack); chk(!ack, "R1", "foreign address nack", ack, 0);
        wbyte(8'h01, ack); chk(!ack, "R1", "foreign data nack", ack, 0);
        b_stop();

        // R2, R4, R3: auto-increment burst over all writable slots
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        wr_burst(8'h11, d, "R4");
        tick(20);

        // R5: pointer held, last write wins
        d = '{8'hA0, 8'hA1, 8'hA2};
        wr_burst(8'h02, d, "R5");
        tick(20);

        // R6 and R4: store to index 0 ignored, next byte lands on index 1
        d = '{8'hEE, 8'h9C};
        wr_burst(8'h10, d, "R6");
        tick(20);

        // R4, R6, R8: read burst across the wrap, entered by repeated START
        b_start();
        wbyte({6'b110000, strap, 1'b0}, ack); chk(ack, "R1", "address ack", ack, 1);
        wbyte(8'h13, ack); chk(ack, "R2", "control ack", ack, 1);
        eptr = 3'd3; eai = 1'b1;
        b_rstart();
        wbyte({6'b110000, strap, 1'b1}, ack); chk(ack, "R1", "read address ack", ack, 1);
        for (int k = 0; k < 5; k++) begin
            m_read(exp);
            rbyte(got, k < 4);
            chk(got == exp, (k == 3) ? "R6" : "R4", "read byte", int'(got), int'(exp));
        end
        // R8: after the NACK the line stays released
        for (int k = 0; k < 8; k++) begin
            rbit(x);
            chk(x == 1'b1, "R8", "released after nack", int'(x), 1);
        end
        b_stop();
        tick(20);

        // R5: read with pointer held repeats the same slot
        b_start();
        wbyte({6'b110000, strap, 1'b0}, ack);
        wbyte(8'h04, ack);
        eptr = 3'd4; eai = 1'b0;
        b_rstart();
        wbyte({6'b110000, strap, 1'b1}, ack);
        for (int k = 0; k < 2; k++) begin
            m_read(exp);
            rbyte(got, k == 0);
            chk(got == exp, "R5", "held read", int'(got), int'(exp));
        end
        b_stop();
        tick(20);

        // R8: STOP in the middle of a byte discards it
        b_start();
        wbyte({6'b110000, strap, 1'b0}, ack);
        wbyte(8'h01, ack);
        for (int k = 0; k < 4; k++) wbit(1'b0);
        b_stop();
        tick(20);
        chk(psc0 == ex[1], "R8", "partial byte discarded", int'(psc0), int'(ex[1]));

        // R1: strap low moves the address
        strap = 1'b0;
        d = '{8'h7B};
        wr_burst(8'h05, d, "R1");
        tick(20);
        chk(sel == 8'h7B, "R1", "strap 0 write", int'(sel), 8'h7B);

        // R7: reset restores defaults
        cmp_en = 1'b0;
        rst_n = 1'b0;
        model_reset();
        tick(4);
        chk({psc0, dut0, psc1, dut1, sel} == 40'h00_80_00_80_00, "R7", "re-reset values",
            int'({psc0, sel}), 0);
        rst_n = 1'b1;
        tick(4);
        cmp_en = 1'b1;
        tick(20);

        // R9: MSB-first ordering seen through a single-byte read of index 0
        lvl = 2'b01;
        b_start();
        wbyte({6'b110000, strap, 1'b0}, ack);
        wbyte(8'h00, ack);
        eptr = 3'd0; eai = 1'b0;
        b_rstart();
        wbyte({6'b110000, strap, 1'b1}, ack);
        m_read(exp);
        rbyte(got, 1'b0);
        chk(got == exp, "R9", "msb-first input read", int'(got), int'(exp));
        b_stop();
        tick(20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule